// File: doc/BRIEF.md
# Shared-Multiplier Symmetric Transposed FIR Engine

This block is the add-and-delay half of a filter bank in which eight input channels share one bank of eight multipliers. On every slot the multiplier bank delivers eight unsigned 8-bit products for one channel. Product j is the input sample times the magnitude of coefficient j, and that magnitude also belongs to the mirror tap 15-j. The engine gives each tap its own sign, adds the signed terms into a 16-tap transposed delay line kept separately for each channel, and emits that channel's filtered sample.

A 3-bit channel index picks the delay-line state and sign word used in the slot. Slots are normally visited round-robin, with the products arriving at eight times the per-channel sample rate. Tap signs are loaded one bit at a time through a serial shift register and committed to a chosen channel with a load strobe. All arithmetic is 12-bit signed with saturation.

Top module: `tdm_sym_fir`

## Requirements
- R1: While `rst` is high on a clock edge, `out_valid`, `out_data` and `out_ch` go to 0, every delay-line register of every channel goes to 0, the serial shift register goes to 0, and every sign bit goes to 0 (all taps positive).
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `out_ch` then equals that slot's `in_ch`.
- R3: The output of a slot is sat(t0 + s0), where s0 is the first stored register of that channel and t_i is the signed term of tap i.
- R4: Transposed update: in a valid slot, channel register k (k = 0..13) becomes sat(t(k+1) + s(k+1)), and register 14 becomes t15. The result is an impulse response equal to the 16 signed coefficients in tap order.
- R5: Symmetry: product j (bits [8j+7:8j] of `in_prod`, j = 0..7) feeds tap j and tap 15-j.
- R6: Sign bit i of a channel's sign word set to 1 makes t_i the two's-complement negation of its product; set to 0, t_i equals the product.
- R7: A cycle with `cfg_shift` high shifts the 16-bit configuration register left by one and puts `cfg_bit` into bit 0, so after 16 shifts the first bit sent sits in bit 15 (tap 15). A cycle with `cfg_load` high copies the register into the sign word of channel `cfg_ch`. Shifting without a load changes no channel's signs.
- R8: A valid slot for one channel leaves the delay-line state and sign word of every other channel unchanged.
- R9: Every addition saturates to the range -2048..2047.
- R10: A cycle with `in_valid` low changes no delay-line state, and `out_data` and `out_ch` hold their values.
- R11: A synchronous reset asserted after operation clears all accumulated state, so the next slot on any channel outputs only its own tap-0 term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Slot carries new products |
| in_ch | input | 3 | Channel of this slot |
| in_prod | input | 64 | Eight unsigned 8-bit magnitude products, product j in bits [8j+7:8j] |
| cfg_bit | input | 1 | Serial sign bit |
| cfg_shift | input | 1 | Shift cfg_bit into the configuration register |
| cfg_load | input | 1 | Commit the configuration register to channel cfg_ch |
| cfg_ch | input | 3 | Channel whose sign word is loaded |
| out_valid | output | 1 | Filtered sample valid |
| out_ch | output | 3 | Channel of the filtered sample |
| out_data | output | 12 | Filtered sample, signed |

## Verification
A corrupted delay-line register of a channel shows up only when that channel is next served. A wrong register k reaches `out_data` after k+1 more slots of that channel, so impulse tests run a full 16 slots per channel to expose every stage. A sign or symmetry error changes the output in the slot where that tap's term reaches tap 0. A slot written to the wrong channel corrupts the other channel's next output, which interleaved round-robin traffic exposes within one rotation.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Index of the product that feeds a tap: taps t and ntap-1-t share one.
  function automatic int mirror_tap(input int t, input int ntap);
    return (t < ntap / 2) ? t : (ntap - 1 - t);
  endfunction
endpackage

// File: rtl/fir_sign_bank.sv
module fir_sign_bank #(
  parameter int NCH  = 8,
  parameter int NTAP = 16,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_bit,
  input  logic            cfg_shift,
  input  logic            cfg_load,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [CHW-1:0]  rd_ch,
  output logic [NTAP-1:0] rd_signs
);
  logic [NTAP-1:0] shreg;
  logic [NTAP-1:0] words [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      for (int c = 0; c < NCH; c++) words[c] <= '0;
    end else begin
      if (cfg_shift) shreg <= {shreg[NTAP-2:0], cfg_bit};
      if (cfg_load)  words[cfg_ch] <= shreg;
    end
  end

  assign rd_signs = words[rd_ch];
endmodule

// File: rtl/fir_state_ram.sv
module fir_state_ram #(
  parameter int NCH = 8,
  parameter int W   = 180,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [CHW-1:0] addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata
);
  logic [W-1:0] mem [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) mem[c] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/fir_tap_slice.sv
module fir_tap_slice #(
  parameter int PW = 8,
  parameter int AW = 12
) (
  input  logic [PW-1:0]        prod,
  input  logic                 neg,
  input  logic signed [AW-1:0] carry,
  output logic signed [AW-1:0] sum
);
  localparam int XW = AW + 2;
  localparam logic signed [XW-1:0] HI = {3'b000, {(AW-1){1'b1}}};
  localparam logic signed [XW-1:0] LO = {3'b111, {(AW-1){1'b0}}};

  logic signed [XW-1:0] mag_x, term_x, carry_x, total_x;

  always_comb begin
    mag_x   = $signed({{(XW-PW){1'b0}}, prod});
    term_x  = neg ? -mag_x : mag_x;
    carry_x = {{2{carry[AW-1]}}, carry};
    total_x = term_x + carry_x;
    if (total_x > HI)      sum = HI[AW-1:0];
    else if (total_x < LO) sum = LO[AW-1:0];
    else                   sum = total_x[AW-1:0];
  end
endmodule

// File: rtl/tdm_sym_fir.sv
module tdm_sym_fir #(
  parameter int NCH  = 8,
  parameter int NTAP = 16,
  parameter int PW   = 8,
  parameter int AW   = 12,
  localparam int CHW  = $clog2(NCH),
  localparam int NMAG = NTAP / 2,
  localparam int SW   = (NTAP - 1) * AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [CHW-1:0]       in_ch,
  input  logic [NMAG*PW-1:0]   in_prod,
  input  logic                 cfg_bit,
  input  logic                 cfg_shift,
  input  logic                 cfg_load,
  input  logic [CHW-1:0]       cfg_ch,
  output logic                 out_valid,
  output logic [CHW-1:0]       out_ch,
  output logic signed [AW-1:0] out_data
);
  import fir_pkg::*;

  logic [NTAP-1:0] signs;
  logic [SW-1:0]   st_rd, st_wr;
  logic signed [AW-1:0] tap_sum [NTAP];

  fir_sign_bank #(.NCH(NCH), .NTAP(NTAP)) u_signs (
    .clk(clk), .rst(rst), .cfg_bit(cfg_bit), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .cfg_ch(cfg_ch), .rd_ch(in_ch), .rd_signs(signs)
  );

  fir_state_ram #(.NCH(NCH), .W(SW)) u_state (
    .clk(clk), .rst(rst), .we(in_valid), .addr(in_ch),
    .wdata(st_wr), .rdata(st_rd)
  );

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    localparam int M = mirror_tap(t, NTAP);
    logic signed [AW-1:0] carry;
    if (t == NTAP - 1) begin : g_end
      assign carry = '0;
    end else begin : g_mid
      assign carry = st_rd[t*AW +: AW];
    end
    fir_tap_slice #(.PW(PW), .AW(AW)) u_slice (
      .prod(in_prod[M*PW +: PW]), .neg(signs[t]),
      .carry(carry), .sum(tap_sum[t])
    );
  end

  for (genvar k = 0; k < NTAP - 1; k++) begin : g_next
    assign st_wr[k*AW +: AW] = tap_sum[k+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_ch   <= in_ch;
        out_data <= tap_sum[0];
      end
    end
  end
endmodule

// File: rtl/fir_checks.sv
module fir_checks #(
  parameter int CHW = 3,
  parameter int AW  = 12
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [CHW-1:0] in_ch,
  input logic           out_valid,
  input logic [CHW-1:0] out_ch,
  input logic [AW-1:0]  out_data
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_channel_tag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_ch == $past(in_ch)));

  a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r10_data_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_ch)));
endmodule

bind tdm_sym_fir fir_checks #(.CHW(CHW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
  .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
);

// File: tb/sim_tdm_sym_fir.sv
module sim_tdm_sym_fir;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_ch;
  logic [63:0] in_prod;
  logic        cfg_bit, cfg_shift, cfg_load;
  logic [2:0]  cfg_ch;
  logic        out_valid;
  logic [2:0]  out_ch;
  logic signed [11:0] out_data;

  int total = 0;
  int bad   = 0;

  int m_st [8][15];
  logic [15:0] m_sign [8];
  logic [15:0] m_sr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_sym_fir u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_prod(in_prod),
    .cfg_bit(cfg_bit), .cfg_shift(cfg_shift), .cfg_load(cfg_load), .cfg_ch(cfg_ch),
    .out_valid(out_valid), .out_ch(out_ch), .out_data(out_data)
  );

  function automatic int clamp12(input int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) begin
      m_sign[c] = '0;
      for (int k = 0; k < 15; k++) m_st[c][k] = 0;
    end
    m_sr = '0;
  endtask

  // R3 R4 R5 R6 R9 behaviour from the requirements
  function automatic int model_slot(input int ch, input logic [63:0] pr);
    int t [16];
    int y;
    for (int i = 0; i < 16; i++) begin
      int m = (i < 8) ? i : 15 - i;
      int mag = int'(pr[m*8 +: 8]);
      t[i] = m_sign[ch][i] ? -mag : mag;
    end
    y = clamp12(t[0] + m_st[ch][0]);
    for (int k = 0; k < 14; k++) m_st[ch][k] = clamp12(t[k+1] + m_st[ch][k+1]);
    m_st[ch][14] = t[15];
    return y;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic slot(input int ch, input logic [63:0] pr, input string req);
    int exp;
    in_ch = ch[2:0];
    in_prod = pr;
    in_valid = 1'b1;
    exp = model_slot(ch, pr);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R2 valid"}, int'(out_valid), 1);
    check({req, " R2 channel"}, int'(out_ch), ch);
    check(req, int'(out_data), exp);
  endtask

  task automatic load_signs(input int ch, input logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      cfg_bit = w[i];
      cfg_shift = 1'b1;
      @(negedge clk);
      m_sr = {m_sr[14:0], w[i]};
    end
    cfg_shift = 1'b0;
    cfg_ch = ch[2:0];
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_sign[ch] = m_sr;
  endtask

  function automatic logic [63:0] ramp();
    logic [63:0] v;
    for (int j = 0; j < 8; j++) v[j*8 +: 8] = 8'(j + 1);
    return v;
  endfunction

  task automatic t_reset_state();
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_data", int'(out_data), 0);
    check("R1 out_ch", int'(out_ch), 0);
  endtask

  task automatic t_impulse();
    slot(3, ramp(), "R3 R5 impulse tap0");
    for (int n = 1; n < 16; n++) slot(3, 64'd0, "R4 R5 impulse tail");
    slot(3, 64'd0, "R4 line drained");
  endtask

  task automatic t_signs();
    load_signs(5, 16'hA5C3);
    slot(5, ramp(), "R6 R7 signed tap0");
    for (int n = 1; n < 16; n++) slot(5, 64'd0, "R6 R7 signed tail");
    // channel 3 signs must still be all positive
    slot(3, ramp(), "R7 other channel signs");
    for (int n = 1; n < 16; n++) slot(3, 64'd0, "R7 other channel tail");
  endtask

  task automatic t_interleave();
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 8; c++) begin
        logic [63:0] v;
        v = {$urandom, $urandom};
        slot(c, v, "R8 round robin");
      end
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++) slot(c, 64'd0, "R8 drain");
  endtask

  task automatic t_saturate();
    logic [63:0] full;
    full = {8{8'hFF}};
    for (int n = 0; n < 20; n++) slot(0, full, "R9 positive climb");
    check("R9 positive limit", int'(out_data), 2047);
    load_signs(1, 16'hFFFF);
    for (int n = 0; n < 20; n++) slot(1, full, "R9 negative climb");
    check("R9 negative limit", int'(out_data), -2048);
  endtask

  task automatic t_idle();
    int held;
    slot(2, ramp(), "R10 prime");
    held = int'(out_data);
    in_ch = 3'd2;
    in_prod = {8{8'h7F}};
    repeat (5) begin
      @(negedge clk);
      check("R10 no valid", int'(out_valid), 0);
      check("R10 data held", int'(out_data), held);
    end
    slot(2, 64'd0, "R10 state untouched");
  endtask

  task automatic t_shift_no_load();
    for (int i = 0; i < 16; i++) begin
      cfg_bit = 1'b1;
      cfg_shift = 1'b1;
      @(negedge clk);
      m_sr = {m_sr[14:0], 1'b1};
    end
    cfg_shift = 1'b0;
    slot(4, ramp(), "R7 shift without load");
    slot(4, 64'd0, "R7 shift without load tail");
  endtask

  task automatic t_midrun_reset();
    slot(6, ramp(), "R11 prefill");
    slot(6, ramp(), "R11 prefill");
    do_reset();
    check("R1 R11 valid after reset", int'(out_valid), 0);
    check("R1 R11 data after reset", int'(out_data), 0);
    slot(6, 64'd0, "R11 cleared state");
    slot(5, ramp(), "R1 R11 signs cleared");
    check("R11 tap0 only", int'(out_data), 1);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_ch = '0; in_prod = '0;
    cfg_bit = 1'b0; cfg_shift = 1'b0; cfg_load = 1'b0; cfg_ch = '0;
    model_reset();
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_impulse();
    t_signs();
    t_interleave();
    t_saturate();
    t_idle();
    t_shift_no_load();
    t_midrun_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule